// File: doc/BRIEF.md
# EEPROM Byte-Write Sequencer

This block fronts a 32-byte on-chip non-volatile array, modelled as a register file, and paces every byte store into it. Software programs a single control register: a block enable, a write-mode bit and a two-bit program-time select. Once write mode is armed, the block holds off all byte stores for a fixed settling window of 1 ms. After that window, one store at a time is accepted. An accepted store raises a busy flag for the selected program time. When that time ends, the new byte lands in the array, busy drops and a one-cycle completion interrupt fires.

All delays are counted in clock cycles. The parameter `CYC_PER_10US` gives the number of clocks in 10 µs, so a bench can run with very short windows. A store that arrives while the block is busy, before settling has finished, or with write mode off does not reach the array. It sets a sticky error flag instead. Reads of the array are combinational. While a program operation is running, the target cell still shows its previous content.

Top module: `eep_write_seq`

## Requirements
- R1: The array has 32 bytes at addresses F800H to F81FH, and the control register is at `CTRL_ADDR` (default F7F0H). A read returns the addressed byte. A read of any other address returns 00H, and a write to any other address changes nothing and sets no flag.
- R2: Control register fields: bit 6 is the enable, bit 0 is write mode, bits 3:2 are the time select, bit 5 is the sticky error flag (writing 1 to it clears it) and bit 7 is busy (read-only). Bits 4 and 1 read as 0. Writing 4CH reads back as 4CH.
- R3: Write mode is armed when both the enable and write-mode bits are 1. A byte store is accepted only if its sampling clock edge comes more than SETTLE = 100*CYC_PER_10US cycles after the edge that armed write mode.
- R4: An accepted store sets busy from the next clock cycle on.
- R5: Busy stays high for exactly T cycles, with T = {93, 186, 278, 371}*CYC_PER_10US for time select 0..3. The time select is captured when the store is accepted.
- R6: A byte store that is not accepted leaves the array unchanged and sets the error flag.
- R7: `done_irq` is high for exactly one cycle, starting at the clock edge where busy falls.
- R8: After reset, the control register reads 00H, busy and `done_irq` are low, and every array byte reads 00H.
- R9: While busy, the target address reads its old value. From the cycle busy falls, it reads the new value.
- R10: Clearing write mode disarms the block. Re-arming starts a new full settling window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 16 | Register or array address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| busy | output | 1 | Program operation in progress |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
A wrong settling count shows up at the ports within one cycle of the first store. That store is either wrongly rejected (the error bit appears) or wrongly accepted (busy rises), so the arming-boundary case separates the two at the exact edge. A wrong program-time counter or a wrongly captured time select moves the interrupt edge. The scoreboard compares that edge against the cycle predicted at acceptance, for all four time selects. A cell that commits too early, or to the wrong index, shows on the next array read, either during busy or right after it.

// File: rtl/eep_write_seq.sv
module eep_write_seq #(
  parameter int          CYC_PER_10US = 2,
  parameter int          DEPTH        = 32,
  parameter logic [15:0] ARRAY_BASE   = 16'hF800,
  parameter logic [15:0] CTRL_ADDR    = 16'hF7F0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        busy,
  output logic        done_irq
);
  localparam int AW         = $clog2(DEPTH);
  localparam int SETTLE_CYC = 100 * CYC_PER_10US;
  localparam int T0 = 93 * CYC_PER_10US;
  localparam int T1 = 186 * CYC_PER_10US;
  localparam int T2 = 278 * CYC_PER_10US;
  localparam int T3 = 371 * CYC_PER_10US;
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int CW = $clog2(T3 + 1);
  localparam logic [16:0] ARR_END = 17'(ARRAY_BASE) + 17'(DEPTH);

  logic          en, wm, err;
  logic [1:0]    tsel;
  logic [SW-1:0] settle_cnt;
  logic [CW-1:0] prog_cnt;
  logic [AW-1:0] pend_idx;
  logic [7:0]    pend_data;
  logic [7:0]    cells [DEPTH];

  function automatic logic [CW-1:0] prog_len(input logic [1:0] s);
    case (s)
      2'd0:    return CW'(T0);
      2'd1:    return CW'(T1);
      2'd2:    return CW'(T2);
      default: return CW'(T3);
    endcase
  endfunction

  wire           hit_ctrl = bus_addr == CTRL_ADDR;
  wire           hit_arr  = (bus_addr >= ARRAY_BASE) && ({1'b0, bus_addr} < ARR_END);
  wire [AW-1:0]  idx      = AW'(bus_addr - ARRAY_BASE);
  wire           armed    = en & wm;
  wire           settled  = settle_cnt == SW'(SETTLE_CYC);
  wire           arr_wr   = bus_we & hit_arr;
  wire           accept   = arr_wr & armed & settled & ~busy;
  wire           reject   = arr_wr & ~accept;
  wire           finish   = busy && (prog_cnt == '0);
  wire           ctrl_wr  = bus_we & hit_ctrl;

  assign bus_rdata = hit_ctrl ? {busy, en, err, 1'b0, tsel, 1'b0, wm}
                   : hit_arr  ? cells[idx]
                   : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      wm   <= 1'b0;
      tsel <= 2'd0;
      err  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en   <= bus_wdata[6];
        wm   <= bus_wdata[0];
        tsel <= bus_wdata[3:2];
        if (bus_wdata[5]) err <= 1'b0;
      end
      if (reject) err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        settle_cnt <= '0;
    else if (!armed)   settle_cnt <= '0;
    else if (!settled) settle_cnt <= settle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      prog_cnt  <= '0;
      pend_idx  <= '0;
      pend_data <= 8'h00;
      done_irq  <= 1'b0;
    end else begin
      done_irq <= finish;
      if (accept) begin
        busy      <= 1'b1;
        prog_cnt  <= prog_len(tsel) - 1'b1;
        pend_idx  <= idx;
        pend_data <= bus_wdata;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        prog_cnt <= prog_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (finish) begin
      cells[pend_idx] <= pend_data;
    end
  end
endmodule

// File: rtl/eep_write_seq_chk.sv
module eep_write_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_rdata,
  input logic        busy,
  input logic        done_irq,
  input logic        err,
  input logic        armed,
  input logic        settled,
  input logic        hit_arr
);
  p_start_settled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed && settled && bus_we && hit_arr));

  p_start_from_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_we));

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  p_irq_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);

  p_busy_store_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_arr && busy) |=> err);

  p_old_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(bus_addr) && hit_arr) |-> $stable(bus_rdata));

  p_disarmed_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !$rose(busy));
endmodule

bind eep_write_seq eep_write_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .busy(busy), .done_irq(done_irq), .err(err),
  .armed(armed), .settled(settled), .hit_arr(hit_arr)
);

// File: tb/eep_write_seq_bench.sv
module eep_write_seq_bench;
  localparam int P      = 2;
  localparam int SETTLE = 100 * P;
  localparam int TT [4] = '{93 * P, 186 * P, 278 * P, 371 * P};
  localparam logic [15:0] CTRL = 16'hF7F0;

  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        busy, done_irq;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q [$];

  eep_write_seq #(.CYC_PER_10US(P)) u_eep_write_seq (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done_irq(done_irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; the store is sampled at edge cyc+1, returns at next negedge
  task automatic wr(input logic [15:0] a, input logic [7:0] d, output int edge_no);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    edge_no = cyc + 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic wr_prog(input logic [15:0] a, input logic [7:0] d, input int sel);
    int e;
    wr(a, d, e);
    exp_q.push_back(e + TT[sel]);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // monitor: completion edge against scoreboard
  always @(negedge clk) begin
    if (rst_n && done_irq) begin
      if (exp_q.size() == 0) check("R7 unexpected irq", 1, 0);
      else check("R5/R7 irq edge", cyc, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R5 actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int e, s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(CTRL, v);        check("R8 ctrl reset", v, 8'h00);
    check("R8 busy reset", busy, 0);
    check("R8 irq reset", done_irq, 0);
    rd(16'hF800, v);    check("R1 R8 first cell", v, 8'h00);
    rd(16'hF81F, v);    check("R1 R8 last cell", v, 8'h00);

    wr(CTRL, 8'h4C, e); rd(CTRL, v); check("R2 readback 4C", v, 8'h4C);

    wr(16'hF805, 8'hA5, e);
    rd(CTRL, v);        check("R6 err mode off", v, 8'h6C);
    rd(16'hF805, v);    check("R6 cell untouched", v, 8'h00);
    check("R6 no busy", busy, 0);
    wr(CTRL, 8'h6C, e); rd(CTRL, v); check("R2 err clear", v, 8'h4C);

    wr(CTRL, 8'h4D, s);
    repeat (SETTLE - 1) @(negedge clk);
    wr(16'hF800, 8'h11, e);
    check("R3 boundary edge", e - s, SETTLE);
    rd(CTRL, v);        check("R3 early store rejected", v, 8'h6D);
    wr_prog(16'hF800, 8'h11, 3);
    check("R4 busy set", busy, 1);
    rd(16'hF800, v);    check("R9 old value while busy", v, 8'h00);
    rd(CTRL, v);        check("R2 busy bit", v, 8'hED);
    wr(16'hF801, 8'h22, e);
    wr(CTRL, 8'h6D, e);
    wait_idle();
    rd(16'hF800, v);    check("R9 new value", v, 8'h11);
    rd(16'hF801, v);    check("R6 busy store dropped", v, 8'h00);
    rd(CTRL, v);        check("R2 idle ctrl", v, 8'h4D);

    wr(CTRL, 8'h41, e);
    wr_prog(16'hF81F, 8'h5A, 0);
    wait_idle();
    rd(16'hF81F, v);    check("R5 sel0 last cell", v, 8'h5A);
    wr(CTRL, 8'h45, e);
    wr_prog(16'hF802, 8'h33, 1);
    wr(CTRL, 8'h49, e);
    wait_idle();
    rd(16'hF802, v);    check("R5 sel1 latched", v, 8'h33);
    wr_prog(16'hF803, 8'h44, 2);
    wait_idle();
    rd(16'hF803, v);    check("R5 sel2", v, 8'h44);

    wr(CTRL, 8'h48, e);
    wr(16'hF804, 8'h77, e);
    rd(CTRL, v);        check("R10 disarmed reject", v, 8'h68);
    rd(16'hF804, v);    check("R10 cell untouched", v, 8'h00);
    wr(CTRL, 8'h6D, e);
    wr(16'hF804, 8'h77, e);
    rd(CTRL, v);        check("R10 rearm resettles", v, 8'h6D);
    check("R10 no busy", busy, 0);

    repeat (SETTLE) @(negedge clk);
    wr(CTRL, 8'h6D, e);
    wr(16'hF820, 8'h99, e);
    rd(CTRL, v);        check("R1 unmapped ignored", v, 8'h4D);
    rd(16'hF820, v);    check("R1 unmapped reads 0", v, 8'h00);

    repeat (4) @(negedge clk);
    check("R5 scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule